// File: doc/BRIEF.md
# Descriptor-Ring DMA Engine

This engine follows a circular table of transfer descriptors in system memory and copies blocks of dwords from system memory to a target space, such as a register aperture or a frame buffer. A descriptor is four dwords long. The first dword is the target offset. The second is the source address in system memory. The third is a command word that carries a byte count and two flags. The fourth is a spare word, which the engine reads and then discards. For each descriptor the engine fetches the four dwords one after another. It then reads the source dwords one at a time and sends each one to the target write port. After that it moves on to the next descriptor, wrapping at the end of the table.

The host sets the table position and the table size through a table command register while the engine is idle. It then starts the engine by writing to a kick register. The engine keeps running until it finishes a descriptor whose command word has the end-of-list flag set. It then goes idle and sets a sticky end-of-list status bit. This status bit can drive an interrupt line. The pointer register lets software track progress: while the engine is idle it shows the next descriptor to be executed, and while the engine is running it shows the descriptor after the one in flight.

Top module: `dma_desc_ring`

## Requirements
- R1: A descriptor is fetched as four single reads at pointer+0, +4, +8 and +12, in that order. Only one read is outstanding at a time. Each request holds its address until `mrd_req_ready` accepts it, and every request address is dword aligned.
- R2: Word 0 gives the target offset and word 1 gives the source address, with bits 1:0 dropped. Each transfer dword is read from the source address, which steps up by 4 per dword. It is then presented on the target write port, where the offset also steps up by 4 per dword.
- R3: When bit 30 of the command word is set, every dword of that descriptor is written to the same target offset, namely the one in word 0.
- R4: Bits 12:0 of the command word hold a byte count. Any count above 4096 is treated as 4096, and the engine moves ceil(count/4) dwords. A count of zero completes the descriptor with no data reads and no target writes.
- R5: When bit 31 of the command word is set, the engine goes idle once that descriptor completes and sets the end-of-list status, which is bit 1 of register 2. When bit 31 is clear, the engine fetches the next descriptor.
- R6: Bits 1:0 of a table command write select a table length of 16 KB << code, where code 0..3 gives 16, 32, 64 or 128 KB. The descriptor after the last entry of the aligned region containing the pointer is the first entry of that region.
- R7: Register 0 reads back with bits 3:0 as zero. While idle it returns the next descriptor to execute. While busy it returns the descriptor after the one executing, wrapped as in R6.
- R8: Bit 0 of register 1 is 1 exactly while the engine is busy.
- R9: While the engine is idle, a write to register 0 sets the pointer from bits 31:4 and the size code. A write to register 3, the kick, then starts the engine. Writes to register 0 and kicks that arrive while the engine is busy have no effect.
- R10: Bit 0 of register 2 enables the interrupt. `irq` is the enable ANDed with the status bit. Writing 1 to bit 1 clears the status, but a new end-of-list event in the same cycle takes priority over the clear.
- R11: While idle, the engine issues no memory requests and no target writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 table/pointer, 1 status, 2 interrupt control, 3 kick |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | End-of-list interrupt |
| mrd_req_valid | output | 1 | Memory read request valid |
| mrd_req_ready | input | 1 | Memory read request accepted |
| mrd_req_addr | output | 32 | Memory read byte address |
| mrd_rsp_valid | input | 1 | Read data valid |
| mrd_rsp_data | input | 32 | Read data |
| tgt_wr_valid | output | 1 | Target write strobe |
| tgt_wr_addr | output | 24 | Target byte offset |
| tgt_wr_data | output | 32 | Target write data |

## Verification
If the word index is off, a wrong field is latched. This shows up on the very next target write as a swapped address or data value, or as a transfer length that does not match the count. A wrong wrap mask or a pointer that fails to advance does not change the current descriptor. Instead, it appears one descriptor later, either as a fetch address outside the table region or as a wrong pointer readback. The bench reads the pointer in the cycle just after the kick, which exposes the look-ahead value before any data moves. An end-of-list flag that is lost keeps the busy bit high and the fetches running, while an end-of-list flag that fires early stops the target writes short of the expected list.

// File: rtl/dma_desc_ring.sv
module dma_desc_ring #(
  parameter int AW         = 32,
  parameter int TGT_AW     = 24,
  parameter int CNT_W      = 13,
  parameter int MAX_BYTES  = 4096,
  parameter int MIN_TBL_LG = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              mrd_req_valid,
  input  logic              mrd_req_ready,
  output logic [AW-1:0]     mrd_req_addr,
  input  logic              mrd_rsp_valid,
  input  logic [31:0]       mrd_rsp_data,
  output logic              tgt_wr_valid,
  output logic [TGT_AW-1:0] tgt_wr_addr,
  output logic [31:0]       tgt_wr_data
);
  localparam int DW_W = $clog2(MAX_BYTES / 4 + 1);
  localparam logic [CNT_W:0] MAXB = (CNT_W + 1)'(MAX_BYTES);
  localparam logic [1:0] A_TBL = 2'd0, A_STAT = 2'd1, A_INT = 2'd2, A_KICK = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_DREQ, S_DWAIT, S_XREQ, S_XWAIT} st_t;

  st_t              state;
  logic [AW-1:0]    ptr_q, src_q;
  logic [1:0]       size_q, widx_q;
  logic [TGT_AW-1:0] tgt_q;
  logic [DW_W-1:0]  left_q;
  logic             hold_q, eol_q, ie_q, is_q;

  logic             busy, desc_done;
  logic [AW-1:0]    tbl_mask, ptr_nxt, ptr_rd;
  logic [CNT_W-1:0] bcnt;
  logic [CNT_W:0]   bclamp, dw_full;
  logic [DW_W-1:0]  dwords;
  logic             unused_bits;

  assign busy     = (state != S_IDLE);
  assign tbl_mask = (AW'(1) << (MIN_TBL_LG + int'(size_q))) - AW'(1);
  assign ptr_nxt  = (ptr_q & ~tbl_mask) | ((ptr_q + AW'(16)) & tbl_mask);
  assign ptr_rd   = busy ? ptr_nxt : ptr_q;

  assign bcnt    = mrd_rsp_data[CNT_W-1:0];
  assign bclamp  = ({1'b0, bcnt} > MAXB) ? MAXB : {1'b0, bcnt};
  assign dw_full = (bclamp + (CNT_W + 1)'(3)) >> 2;
  assign dwords  = dw_full[DW_W-1:0];

  assign desc_done = ((state == S_DWAIT) && mrd_rsp_valid && (widx_q == 2'd3) && (left_q == '0))
                  || ((state == S_XWAIT) && mrd_rsp_valid && (left_q == DW_W'(1)));

  assign mrd_req_valid = (state == S_DREQ) || (state == S_XREQ);
  assign mrd_req_addr  = (state == S_DREQ) ? (ptr_q | AW'({widx_q, 2'b00})) : src_q;

  assign tgt_wr_valid = (state == S_XWAIT) && mrd_rsp_valid;
  assign tgt_wr_addr  = tgt_q;
  assign tgt_wr_data  = mrd_rsp_data;

  assign irq = ie_q & is_q;

  always_comb begin
    case (reg_addr)
      A_TBL:   reg_rdata = 32'(ptr_rd) & 32'hFFFF_FFF0;
      A_STAT:  reg_rdata = {31'b0, busy};
      A_INT:   reg_rdata = {30'b0, is_q, ie_q};
      default: reg_rdata = 32'b0;
    endcase
  end

  assign unused_bits = ^{mrd_rsp_data, reg_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ptr_q  <= '0;
      src_q  <= '0;
      size_q <= '0;
      widx_q <= '0;
      tgt_q  <= '0;
      left_q <= '0;
      hold_q <= 1'b0;
      eol_q  <= 1'b0;
      ie_q   <= 1'b0;
      is_q   <= 1'b0;
    end else begin
      if (reg_wr_en && reg_addr == A_INT) begin
        ie_q <= reg_wdata[0];
        if (reg_wdata[1]) is_q <= 1'b0;
      end
      if (desc_done && eol_q) is_q <= 1'b1;

      case (state)
        S_IDLE: begin
          if (reg_wr_en && reg_addr == A_TBL) begin
            ptr_q  <= AW'(reg_wdata) & ~AW'(15);
            size_q <= reg_wdata[1:0];
          end
          if (reg_wr_en && reg_addr == A_KICK) begin
            state  <= S_DREQ;
            widx_q <= 2'd0;
          end
        end
        S_DREQ: if (mrd_req_ready) state <= S_DWAIT;
        S_DWAIT: if (mrd_rsp_valid) begin
          widx_q <= widx_q + 2'd1;
          case (widx_q)
            2'd0: tgt_q <= mrd_rsp_data[TGT_AW-1:0];
            2'd1: src_q <= AW'(mrd_rsp_data) & ~AW'(3);
            2'd2: begin
              eol_q  <= mrd_rsp_data[31];
              hold_q <= mrd_rsp_data[30];
              left_q <= dwords;
            end
            default: ;
          endcase
          if (widx_q != 2'd3)       state <= S_DREQ;
          else if (left_q != '0)    state <= S_XREQ;
        end
        S_XREQ: if (mrd_req_ready) state <= S_XWAIT;
        S_XWAIT: if (mrd_rsp_valid) begin
          src_q  <= src_q + AW'(4);
          if (!hold_q) tgt_q <= tgt_q + TGT_AW'(4);
          left_q <= left_q - DW_W'(1);
          state  <= S_XREQ;
        end
        default: state <= S_IDLE;
      endcase

      if (desc_done) begin
        ptr_q  <= ptr_nxt;
        widx_q <= 2'd0;
        state  <= eol_q ? S_IDLE : S_DREQ;
      end
    end
  end
endmodule

// File: rtl/dma_desc_ring_chk.sv
module dma_desc_ring_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          eol_sts,
  input logic          mrd_req_valid,
  input logic          mrd_req_ready,
  input logic [AW-1:0] mrd_req_addr,
  input logic          tgt_wr_valid
);
  p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_req_valid && !mrd_req_ready |=> mrd_req_valid && $stable(mrd_req_addr));

  p_req_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_req_valid |-> mrd_req_addr[1:0] == 2'b00);

  p_single_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_wr_valid |=> !tgt_wr_valid);

  p_eol_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eol_sts) |-> $past(busy) && !busy);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mrd_req_valid && !tgt_wr_valid);
endmodule

bind dma_desc_ring dma_desc_ring_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .eol_sts       (is_q),
  .mrd_req_valid (mrd_req_valid),
  .mrd_req_ready (mrd_req_ready),
  .mrd_req_addr  (mrd_req_addr),
  .tgt_wr_valid  (tgt_wr_valid)
);

// File: tb/sim_dma_desc_ring.sv
`timescale 1ns/1ps
module sim_dma_desc_ring;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        mrd_req_valid;
  logic        mrd_req_ready = 1'b0;
  logic [31:0] mrd_req_addr;
  logic        mrd_rsp_valid = 1'b0;
  logic [31:0] mrd_rsp_data = 32'd0;
  logic        tgt_wr_valid;
  logic [23:0] tgt_wr_addr;
  logic [31:0] tgt_wr_data;

  always #2.5 clk = ~clk;

  dma_desc_ring u0 (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq),
    .mrd_req_valid(mrd_req_valid), .mrd_req_ready(mrd_req_ready), .mrd_req_addr(mrd_req_addr),
    .mrd_rsp_valid(mrd_rsp_valid), .mrd_rsp_data(mrd_rsp_data),
    .tgt_wr_valid(tgt_wr_valid), .tgt_wr_addr(tgt_wr_addr), .tgt_wr_data(tgt_wr_data)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] wa[$], wd[$], ea[$], ed[$];

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : ~a;
  endfunction

  // memory model: random accept stalls, 1..3 cycle read latency
  logic [7:0]  lfsr = 8'h5A;
  logic        pend = 1'b0;
  logic [1:0]  pend_cnt = 2'd0;
  logic [31:0] pend_addr = 32'd0;
  always @(posedge clk) begin
    lfsr          <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mrd_req_ready <= lfsr[0] | lfsr[3];
    mrd_rsp_valid <= 1'b0;
    if (pend) begin
      if (pend_cnt == 2'd0) begin
        mrd_rsp_valid <= 1'b1;
        mrd_rsp_data  <= rd(pend_addr);
        pend          <= 1'b0;
      end else pend_cnt <= pend_cnt - 2'd1;
    end
    if (mrd_req_valid && mrd_req_ready) begin
      pend      <= 1'b1;
      pend_addr <= mrd_req_addr;
      pend_cnt  <= 2'(lfsr[2:1] % 3);
    end
    if (tgt_wr_valid) begin
      wa.push_back({8'b0, tgt_wr_addr});
      wd.push_back(tgt_wr_data);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] t, input logic [31:0] s,
                          input logic [31:0] c);
    mem[a] = t; mem[a + 4] = s; mem[a + 8] = c; mem[a + 12] = 32'hDEAD_BEEF;
  endtask

  task automatic expect_run(input logic [31:0] t, input logic [31:0] s, input int n, input bit hold);
    for (int i = 0; i < n; i++) begin
      ea.push_back(hold ? t : t + 32'(4 * i));
      ed.push_back(rd(s + 32'(4 * i)));
    end
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk); reg_read(2'd1, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  task automatic cmp_writes(input string rq);
    chk({rq, " write count"}, 32'(wa.size()), 32'(ea.size()));
    if (wa.size() == ea.size())
      for (int i = 0; i < ea.size(); i++) begin
        if (wa[i] !== ea[i] || wd[i] !== ed[i]) begin
          chk({rq, " write addr"}, wa[i], ea[i]);
          chk({rq, " write data"}, wd[i], ed[i]);
          break;
        end
      end
    wa.delete(); wd.delete(); ea.delete(); ed.delete();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_read(2'd0, v); chk("R7 reset pointer", v, 32'h0);
    reg_read(2'd1, v); chk("R8 reset status", v, 32'h0);
    reg_read(2'd2, v); chk("R10 reset int ctl", v, 32'h0);
    chk("R10 reset irq", 32'(irq), 32'h0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    put_desc(32'h1_0000, 32'h100, 32'h8_2000, 32'h8000_000C);
    expect_run(32'h100, 32'h8_2000, 3, 1'b0);
    reg_write(2'd0, 32'h1_0000);
    reg_write(2'd3, 32'h0);
    reg_read(2'd1, v); chk("R8 busy after kick", v, 32'h1);
    reg_read(2'd0, v); chk("R7 pointer look-ahead while busy", v, 32'h1_0010);
    wait_idle();
    cmp_writes("R2 R1 single descriptor");
    reg_read(2'd0, v); chk("R7 pointer after list", v, 32'h1_0010);
    reg_read(2'd2, v); chk("R5 end-of-list status", v, 32'h2);
    chk("R10 irq masked", 32'(irq), 32'h0);
    reg_write(2'd2, 32'h2);
  endtask

  task automatic t_hold_chain();
    put_desc(32'h1_0100, 32'h200, 32'h8_3000, 32'h4000_0008);
    put_desc(32'h1_0110, 32'h280, 32'h8_3800, 32'h0000_0000);
    put_desc(32'h1_0120, 32'h300, 32'h8_4000, 32'h8000_0005);
    expect_run(32'h200, 32'h8_3000, 2, 1'b1);
    expect_run(32'h300, 32'h8_4000, 2, 1'b0);
    reg_write(2'd0, 32'h1_0100);
    reg_write(2'd3, 32'h0);
    wait_idle();
    cmp_writes("R3 R4 hold, zero count, partial dword");
    reg_write(2'd2, 32'h2);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    put_desc(32'h1_3FF0, 32'h400, 32'h8_5000, 32'h0000_0004);
    put_desc(32'h1_0000, 32'h500, 32'h8_5100, 32'h8000_0004);
    expect_run(32'h400, 32'h8_5000, 1, 1'b0);
    expect_run(32'h500, 32'h8_5100, 1, 1'b0);
    reg_write(2'd0, 32'h1_3FF0);
    reg_write(2'd3, 32'h0);
    reg_read(2'd0, v); chk("R6 busy pointer wraps 16KB", v, 32'h1_0000);
    wait_idle();
    cmp_writes("R6 16KB wrap");
    reg_read(2'd0, v); chk("R6 pointer after wrap", v, 32'h1_0010);

    put_desc(32'h1_4000, 32'h600, 32'h8_5200, 32'h8000_0004);
    expect_run(32'h400, 32'h8_5000, 1, 1'b0);
    expect_run(32'h600, 32'h8_5200, 1, 1'b0);
    reg_write(2'd0, 32'h1_3FF1);
    reg_write(2'd3, 32'h0);
    wait_idle();
    cmp_writes("R6 32KB table no wrap");
    reg_read(2'd0, v); chk("R7 low nibble zero with size code", v, 32'h1_4010);
    reg_write(2'd2, 32'h2);
  endtask

  task automatic t_clamp();
    put_desc(32'h1_0200, 32'h1000, 32'h9_0000, 32'h8000_1FFF);
    expect_run(32'h1000, 32'h9_0000, 1024, 1'b0);
    reg_write(2'd0, 32'h1_0200);
    reg_write(2'd3, 32'h0);
    wait_idle();
    cmp_writes("R4 count clamp to 4096");
    reg_write(2'd2, 32'h2);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    put_desc(32'h1_0300, 32'h700, 32'h8_6000, 32'h8000_0004);
    expect_run(32'h700, 32'h8_6000, 1, 1'b0);
    reg_write(2'd2, 32'h1);
    reg_write(2'd0, 32'h1_0300);
    reg_write(2'd3, 32'h0);
    chk("R10 irq low while busy", 32'(irq), 32'h0);
    wait_idle();
    cmp_writes("R10 interrupt run");
    chk("R10 irq raised", 32'(irq), 32'h1);
    reg_write(2'd2, 32'h3);
    chk("R10 irq cleared by write-1", 32'(irq), 32'h0);
    reg_read(2'd2, v); chk("R10 int ctl after clear", v, 32'h1);
    reg_write(2'd2, 32'h0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    put_desc(32'h1_0400, 32'h800, 32'h8_7000, 32'h0000_0040);
    put_desc(32'h1_0410, 32'h900, 32'h8_7100, 32'h8000_0010);
    expect_run(32'h800, 32'h8_7000, 16, 1'b0);
    expect_run(32'h900, 32'h8_7100, 4, 1'b0);
    reg_write(2'd0, 32'h1_0400);
    reg_write(2'd3, 32'h0);
    reg_write(2'd0, 32'h5_0003);
    reg_write(2'd3, 32'h0);
    wait_idle();
    cmp_writes("R9 writes while busy ignored");
    reg_read(2'd0, v); chk("R9 pointer unaffected", v, 32'h1_0420);
    reg_write(2'd2, 32'h2);
  endtask

  task automatic t_idle();
    int bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (mrd_req_valid || tgt_wr_valid) bad++;
    end
    chk("R11 idle quiet", 32'(bad), 32'h0);
    chk("R11 no target writes idle", 32'(wa.size()), 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_hold_chain();
    t_wrap();
    t_clamp();
    t_irq();
    t_busy_ignore();
    t_idle();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule